// File: doc/BRIEF.md
# Stack Pointer with High-Water Mark

This block holds the 8-bit stack pointer of an 8051-compatible core. A push strobe moves the pointer up by one before the stack write, so the write goes to the new value on the following cycle. A pop strobe moves it down by one after the read. Software can also load the pointer directly. This is how a program moves its stack clear of the register banks, for example to 0x80 or higher.

Next to the pointer sits a sticky high-water register. It holds the largest pointer value seen since reset. Each new pointer value updates it on the same clock edge, whether the value came from a push, a pop or a direct load. A debug port reads the high-water value at one fixed address, so a runaway stack can be found after the fact. Every other debug address reads as zero from this block.

Top module: `stack_watch`

## Requirements
- R1: While and after reset (rst_n low, active-low), sp_o is 0x07 and spmax_o is 0x07. The first push therefore lands at 0x08.
- R2: A cycle with push_i high, pop_i low and sp_wr_i low makes sp_o equal the old value plus one, modulo 256, after the next rising edge.
- R3: A cycle with pop_i high, push_i low and sp_wr_i low makes sp_o equal the old value minus one, modulo 256, after the next rising edge.
- R4: When push_i and pop_i are both high, clash_o is high in that same cycle, combinationally. If sp_wr_i is also low, sp_o keeps its value across the edge. When push_i and pop_i are not both high, clash_o is low.
- R5: When sp_wr_i is high, sp_o takes sp_wdata_i after the next rising edge, whatever push_i and pop_i are doing.
- R6: After every rising edge, spmax_o equals the larger of its previous value and the new sp_o. It never decreases, and it never goes below sp_o.
- R7: Once sp_o has reached 0xFF, spmax_o stays at 0xFF. This holds through a wrap of sp_o from 0xFF to 0x00 and through any later pops or loads.
- R8: dbg_rdata_o equals spmax_o in the same cycle when dbg_addr_i is 0x1A. For any other dbg_addr_i it is 0x00.
- R9: A cycle with push_i, pop_i and sp_wr_i all low leaves sp_o and spmax_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe: pre-increment the pointer |
| pop_i | input | 1 | Pop strobe: post-decrement the pointer |
| sp_wr_i | input | 1 | Direct software load of the pointer |
| sp_wdata_i | input | 8 | Value loaded when sp_wr_i is high |
| dbg_addr_i | input | 8 | Debug read address |
| sp_o | output | 8 | Current stack pointer (stack RAM address) |
| spmax_o | output | 8 | Recorded high-water pointer value |
| dbg_rdata_o | output | 8 | Debug read data: spmax_o at 0x1A, else zero |
| clash_o | output | 1 | Push and pop requested in the same cycle |

## Verification
The assertions assume rst_n starts low and is held for at least one rising edge. They also assume the strobes, load data and debug address are steady around each rising edge. A push and a pop in the same cycle is treated as a legal input that must raise clash_o, not as a forbidden one. The stimulus changes every input only on falling edges. It deliberately mixes clashes, loads that collide with strobes, loads below the current maximum, wraps in both directions, and debug addresses on and off the match.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_W = 8;
  typedef logic [SP_W-1:0] sp_t;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLASH = 3'd4
  } sp_op_e;

  // Classify one cycle of requests; a load outranks the strobes.
  function automatic sp_op_e sp_classify(logic push, logic pop, logic load);
    if (load)              return OP_LOAD;
    else if (push && pop)  return OP_CLASH;
    else if (push)         return OP_PUSH;
    else if (pop)          return OP_POP;
    else                   return OP_HOLD;
  endfunction

  // Next pointer value for an operation; arithmetic wraps modulo 2**SP_W.
  function automatic sp_t sp_step(sp_op_e op, sp_t cur, sp_t wdata);
    case (op)
      OP_PUSH: return cur + sp_t'(1);
      OP_POP:  return cur - sp_t'(1);
      OP_LOAD: return wdata;
      default: return cur;
    endcase
  endfunction

  function automatic sp_t sp_larger(sp_t a, sp_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic sp_is_top(sp_t v);
    return &v;
  endfunction
endpackage

// File: rtl/sp_update.sv
module sp_update
  import sp_pkg::*;
#(
  parameter sp_t RST_VAL = 8'h07
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  logic load_i,
  input  sp_t  wdata_i,
  output sp_t  sp_o,
  output sp_t  sp_next_o,
  output logic clash_o,
  output logic wrap_o
);
  sp_op_e op;
  sp_t    sp_q;
  sp_t    sp_d;

  // Named events for the checks.
  logic ev_push, ev_pop, ev_load, ev_clash, ev_hold;

  always_comb begin
    op   = sp_classify(push_i, pop_i, load_i);
    sp_d = sp_step(op, sp_q, wdata_i);
  end

  assign ev_push  = (op == OP_PUSH);
  assign ev_pop   = (op == OP_POP);
  assign ev_load  = (op == OP_LOAD);
  assign ev_clash = (op == OP_CLASH);
  assign ev_hold  = (op == OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= RST_VAL;
    else        sp_q <= sp_d;
  end

  assign sp_o      = sp_q;
  assign sp_next_o = sp_d;
  assign clash_o   = push_i & pop_i;
  assign wrap_o    = ev_push & sp_is_top(sp_q);

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (sp_q == sp_t'($past(sp_q) + sp_t'(1)))); // R2
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (sp_q == sp_t'($past(sp_q) - sp_t'(1)))); // R3
  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !load_i) |=> $stable(sp_q)); // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sp_q == $past(wdata_i))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !load_i) |=> $stable(sp_q)); // R9
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ev_push, ev_pop, ev_load, ev_clash, ev_hold})); // R4
endmodule

// File: rtl/hwm_track.sv
module hwm_track
  import sp_pkg::*;
#(
  parameter sp_t RST_VAL = 8'h07
) (
  input  logic clk,
  input  logic rst_n,
  input  sp_t  sp_i,
  input  sp_t  sp_next_i,
  input  logic wrap_i,
  output sp_t  max_o
);
  sp_t  max_q;
  logic ev_raise;

  assign ev_raise = sp_next_i > max_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        max_q <= RST_VAL;
    else if (ev_raise) max_q <= sp_larger(max_q, sp_next_i);
  end

  assign max_o = max_q;

  AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (max_q >= $past(max_q))); // R6
  AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    max_q >= sp_i); // R6
  AST_MAX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> (max_q == {SP_W{1'b1}})); // R7
  AST_MAX_STICKY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    sp_is_top(max_q) |=> sp_is_top(max_q)); // R7
endmodule

// File: rtl/dbg_readmux.sv
module dbg_readmux
  import sp_pkg::*;
#(
  parameter int            ADDR_W = 8,
  parameter [ADDR_W-1:0]   MATCH  = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  sp_t               max_i,
  output sp_t               rdata_o
);
  logic ev_hit;

  assign ev_hit  = (addr_i == MATCH);
  assign rdata_o = ev_hit ? max_i : '0;

  AST_DBG_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit |-> (rdata_o == '0)); // R8
  AST_DBG_HIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> (rdata_o == max_i)); // R8
endmodule

// File: rtl/stack_watch.sv
module stack_watch
  import sp_pkg::*;
#(
  parameter sp_t         RST_VAL  = 8'h07,
  parameter int          DBG_AW   = 8,
  parameter [DBG_AW-1:0] DBG_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              sp_wr_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  input  logic [DBG_AW-1:0] dbg_addr_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [SP_W-1:0]   spmax_o,
  output logic [SP_W-1:0]   dbg_rdata_o,
  output logic              clash_o
);
  sp_t  sp_cur, sp_nxt, max_val;
  logic wrap_ev;

  sp_update #(.RST_VAL(RST_VAL)) u_sp (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .load_i(sp_wr_i), .wdata_i(sp_wdata_i), .sp_o(sp_cur),
    .sp_next_o(sp_nxt), .clash_o(clash_o), .wrap_o(wrap_ev)
  );

  hwm_track #(.RST_VAL(RST_VAL)) u_hwm (
    .clk(clk), .rst_n(rst_n), .sp_i(sp_cur), .sp_next_i(sp_nxt),
    .wrap_i(wrap_ev), .max_o(max_val)
  );

  dbg_readmux #(.ADDR_W(DBG_AW), .MATCH(DBG_ADDR)) u_dbg (
    .clk(clk), .rst_n(rst_n), .addr_i(dbg_addr_i), .max_i(max_val),
    .rdata_o(dbg_rdata_o)
  );

  assign sp_o    = sp_cur;
  assign spmax_o = max_val;

  AST_RESET_VALUES: assert property (@(posedge clk)
    $rose(rst_n) |-> (sp_o == RST_VAL && spmax_o == RST_VAL)); // R1
endmodule

// File: tb/tb_stack_watch.sv
`timescale 1ns/1ps
module tb_stack_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, sp_wr_i = 1'b0;
  logic [7:0] sp_wdata_i = 8'h00, dbg_addr_i = 8'h00;
  logic [7:0] sp_o, spmax_o, dbg_rdata_o;
  logic       clash_o;

  int checks = 0, errors = 0;
  int ref_sp = 7, ref_max = 7;
  bit done = 0;

  always #2 clk = ~clk;

  stack_watch dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .sp_wr_i(sp_wr_i), .sp_wdata_i(sp_wdata_i), .dbg_addr_i(dbg_addr_i),
    .sp_o(sp_o), .spmax_o(spmax_o), .dbg_rdata_o(dbg_rdata_o), .clash_o(clash_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock with the given requests; compares against the model.
  task automatic step(bit pu, bit po, bit wr, int wd, int ad, string mtag = "R6");
    string stag;
    push_i = pu; pop_i = po; sp_wr_i = wr;
    sp_wdata_i = 8'(wd); dbg_addr_i = 8'(ad);
    #1;
    chk("R4 clash", int'(clash_o), (pu && po) ? 1 : 0);
    chk("R8 dbg", int'(dbg_rdata_o), (ad == 8'h1A) ? ref_max : 0);
    if (wr)             begin ref_sp = wd;                  stag = "R5 load"; end
    else if (pu && po)  begin                               stag = "R4 hold"; end
    else if (pu)        begin ref_sp = (ref_sp + 1) % 256;  stag = "R2 push"; end
    else if (po)        begin ref_sp = (ref_sp + 255) % 256; stag = "R3 pop"; end
    else                begin                               stag = "R9 idle"; end
    if (ref_sp > ref_max) ref_max = ref_sp;
    @(negedge clk);
    chk(stag, int'(sp_o), ref_sp);
    chk(mtag, int'(spmax_o), ref_max);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1 sp reset", int'(sp_o), 7);
    chk("R1 max reset", int'(spmax_o), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp after release", int'(sp_o), 7);
    chk("R1 max after release", int'(spmax_o), 7);

    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 8'h1A);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 8'h1A);
    step(1, 1, 0, 0, 8'h00);          // R4 clash holds
    step(0, 0, 0, 0, 8'h1B);          // R9 idle
    step(1, 1, 1, 8'h80, 8'h1A);      // R5 load beats clash
    step(1, 0, 0, 0, 8'h19);
    step(0, 1, 1, 8'h10, 8'h1A);      // lower load, max holds
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 8'hFF);
    step(0, 0, 1, 8'hFE, 8'h1A);
    step(1, 0, 0, 0, 8'h1A, "R7");
    step(1, 0, 0, 0, 8'h1A, "R7");    // wrap to 0x00
    step(1, 0, 0, 0, 8'h1A, "R7");
    step(0, 1, 0, 0, 8'h1A, "R7");
    step(0, 1, 0, 0, 8'h1A, "R7");    // wrap down to 0xFF
    step(0, 0, 1, 8'h05, 8'h1A, "R7");
    chk("R7 saturated", int'(spmax_o), 8'hFF);

    // restart from reset for a random mix below the top
    rst_n = 1'b0; ref_sp = 7; ref_max = 7;
    @(negedge clk);
    chk("R1 second reset", int'(spmax_o), 7);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], (lfsr[5:2] == 4'd0), {1'b0, lfsr[12:6]},
           lfsr[3] ? 8'h1A : {3'b000, lfsr[15:11]});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule